// File: doc/BRIEF.md
# Byte-wide EDAC memory access sequencer

The sequencer sits between a word-wide requester and an external memory with an 8-bit data bus. Each 32-bit read or write becomes four single-byte accesses, most significant byte first at the lowest address. When error protection is on, a fifth access to a check byte follows. The check byte lives in the same device at a mirrored, bit-inverted high address. On writes, the block builds a 7-bit SEC-DED code over the word and stores it. On reads, it recomputes the code, corrects any single-bit error and flags the result as correctable or uncorrectable.

A bank chip select is decoded once, when a request is accepted. The decode uses a programmable bank-size field: the bank size is 8 KiB shifted left by the field value, and bank n starts at n times that size within a 512 MiB space. Four bank selects are produced. The same select stays asserted through the data bytes and through the check-byte access, even though the check-byte address falls elsewhere in the space.

Top module: `edac_byte_seq`

## Requirements
- R1: After reset, `req_ready_o` is 1, `mem_cs_o` is 0 and `rsp_valid_o` is 0. The bank-size field resets to 15, which gives two 256 MiB banks, and protection resets to enabled.
- R2: With protection on, a request makes five accesses, one per cycle. The data bytes go to A, A+1, A+2 and A+3, where A is the request address with bits 1:0 cleared. The byte at A carries data bits 31:24, and the byte at A+3 carries bits 7:0.
- R3: The fifth access goes to the address formed by A[31:28], then two 1 bits, then the inverse of A[27:2].
- R4: The bank index is A[28:0] shifted right by 13 plus the bank-size field. `mem_cs_o` bit n is set for index n when n is below 4. An index of 4 or more selects no bank and drives no strobe.
- R5: `mem_cs_o` holds one value, unchanged, from the first data byte through the check byte.
- R6: On a write, the stored check byte has bit 7 equal to 0. Reading back unmodified memory returns the written word with both error flags low.
- R7: When exactly one of the 32 data bits or 7 code bits (check byte bits 6:0) differs from what was written, a read returns the written word with `rsp_corr_o` high and `rsp_uncorr_o` low.
- R8: When two of those bits differ, a read returns the raw assembled bytes with `rsp_uncorr_o` high and `rsp_corr_o` low.
- R9: With protection off, only the four data bytes are accessed. Reads return the raw bytes, and both flags stay low.
- R10: A request is taken only when `req_valid_i` and `req_ready_o` are both high at a clock edge. Requests raised while busy are ignored. Every accepted request yields exactly one single-cycle `rsp_valid_o` pulse.
- R11: A configuration write in the same cycle as a request acceptance does not affect that request's decode. It applies from the next request onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration register write strobe |
| cfg_bank_sz_i | input | 4 | New bank-size field value |
| cfg_edac_en_i | input | 1 | New protection enable |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Sequencer idle and able to take a request |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 32 | Byte address (bits 1:0 ignored) |
| req_wdata_i | input | 32 | Write word |
| rsp_valid_o | output | 1 | One-cycle completion pulse |
| rsp_rdata_o | output | 32 | Read word (0 for writes) |
| rsp_corr_o | output | 1 | Single-bit error corrected |
| rsp_uncorr_o | output | 1 | Uncorrectable error detected |
| mem_cs_o | output | 4 | Per-bank select, active high |
| mem_addr_o | output | 32 | Byte address to memory |
| mem_we_o | output | 1 | Byte write strobe |
| mem_wdata_o | output | 8 | Byte written |
| mem_rdata_i | input | 8 | Byte read |

## Verification
Two events can land on the same clock edge: a bank-size write and the acceptance of a request whose decode depends on that field. The bench drives both on one edge, changing the size from 512 KiB to 256 MiB for an address at 0x0008_0000. It expects the old bank 1 select on that request and bank 0 on the next request to the same address. A second overlap comes from a request raised while a transfer is still running. The bench judges it by checking that the second address never reaches the memory port and that only one response pulse appears.

// File: rtl/edac_pkg.sv
package edac_pkg;
  localparam int DW    = 32;
  localparam int CW    = 6;
  localparam int NPOS  = DW + CW + 1;

  typedef enum logic [1:0] {ST_IDLE, ST_ACC, ST_RESP} seq_st_e;

  // Hamming positions 1..NPOS-1, data at non-power-of-two slots
  function automatic logic [CW-1:0] ham_bits(input logic [DW-1:0] d);
    logic [CW-1:0] c;
    int j;
    c = '0;
    j = 0;
    for (int pos = 3; pos < NPOS; pos++) begin
      if ((pos & (pos - 1)) != 0) begin
        if (d[j]) c = c ^ pos[CW-1:0];
        j++;
      end
    end
    return c;
  endfunction

  function automatic logic [7:0] ck_encode(input logic [DW-1:0] d);
    logic [CW-1:0] c;
    c = ham_bits(d);
    return {1'b0, (^d) ^ (^c), c};
  endfunction

  function automatic logic [DW-1:0] flip_mask(input logic [CW-1:0] s);
    logic [DW-1:0] m;
    int j;
    m = '0;
    j = 0;
    for (int pos = 3; pos < NPOS; pos++) begin
      if ((pos & (pos - 1)) != 0) begin
        if (s == pos[CW-1:0]) m[j] = 1'b1;
        j++;
      end
    end
    return m;
  endfunction
endpackage

// File: rtl/edac_cfg_reg.sv
module edac_cfg_reg #(
  parameter int          BSZ_W   = 4,
  parameter logic [3:0]  RST_BSZ = 4'd15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [BSZ_W-1:0] bsz_i,
  input  logic             en_i,
  output logic [BSZ_W-1:0] bsz_o,
  output logic             en_o
);
  logic [BSZ_W-1:0] bsz_q;
  logic             en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bsz_q <= RST_BSZ[BSZ_W-1:0];
      en_q  <= 1'b1;
    end else if (we_i) begin
      bsz_q <= bsz_i;
      en_q  <= en_i;
    end
  end

  assign bsz_o = bsz_q;
  assign en_o  = en_q;

  p_cfg_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(bsz_q) && $stable(en_q));
endmodule

// File: rtl/edac_bank_dec.sv
module edac_bank_dec #(
  parameter int AW         = 32,
  parameter int SPACE_W    = 29,
  parameter int BASE_SHIFT = 13,
  parameter int BSZ_W      = 4,
  parameter int NBANK      = 4
) (
  input  logic [AW-1:0]    addr_i,
  input  logic [BSZ_W-1:0] bsz_i,
  output logic [NBANK-1:0] cs_o
);
  logic [SPACE_W-1:0] rel;
  logic [SPACE_W-1:0] idx;

  assign rel = addr_i[SPACE_W-1:0];
  assign idx = rel >> (BASE_SHIFT + int'(bsz_i));

  for (genvar b = 0; b < NBANK; b++) begin : g_cs
    assign cs_o[b] = (idx == SPACE_W'(b));
  end

  always_comb begin
    p_cs_onehot_r4: assert ($onehot0(cs_o));
  end
endmodule

// File: rtl/edac_secded_chk.sv
module edac_secded_chk
  import edac_pkg::*;
(
  input  logic          en_i,
  input  logic [DW-1:0] data_i,
  input  logic [7:0]    ck_i,
  output logic [DW-1:0] data_o,
  output logic          corr_o,
  output logic          uncorr_o
);
  logic [CW-1:0] syn;
  logic          par;

  assign syn = ham_bits(data_i) ^ ck_i[CW-1:0];
  assign par = (^data_i) ^ (^ck_i[CW:0]);

  always_comb begin
    data_o   = data_i;
    corr_o   = 1'b0;
    uncorr_o = 1'b0;
    if (en_i) begin
      if (par) begin
        corr_o = 1'b1;
        data_o = data_i ^ flip_mask(syn);  // code-bit hit leaves data as is
      end else if (syn != '0) begin
        uncorr_o = 1'b1;
      end
    end
  end

  always_comb begin
    p_flag_excl_r8: assert (!(corr_o && uncorr_o));
  end
endmodule

// File: rtl/edac_byte_seq.sv
module edac_byte_seq
  import edac_pkg::*;
#(
  parameter int NBANK = 4,
  parameter int BSZ_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [BSZ_W-1:0] cfg_bank_sz_i,
  input  logic             cfg_edac_en_i,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic             req_we_i,
  input  logic [31:0]      req_addr_i,
  input  logic [31:0]      req_wdata_i,
  output logic             rsp_valid_o,
  output logic [31:0]      rsp_rdata_o,
  output logic             rsp_corr_o,
  output logic             rsp_uncorr_o,
  output logic [NBANK-1:0] mem_cs_o,
  output logic [31:0]      mem_addr_o,
  output logic             mem_we_o,
  output logic [7:0]       mem_wdata_o,
  input  logic [7:0]       mem_rdata_i
);
  localparam int NBYTE = DW / 8;
  localparam int IW    = $clog2(NBYTE + 1);

  seq_st_e          st_q;
  logic [IW-1:0]    idx_q;
  logic [31:0]      addr_q;
  logic [31:0]      wdata_q;
  logic [7:0]       ck_q;
  logic             we_q;
  logic             edac_q;
  logic [NBANK-1:0] cs_q;
  logic [7:0]       rbuf_q [NBYTE];
  logic [7:0]       rck_q;

  logic [BSZ_W-1:0] bsz;
  logic             edac_en;
  logic [NBANK-1:0] cs_dec;
  logic             accept;
  logic             last_acc;
  logic [31:0]      ck_addr;
  logic [31:0]      rd_word;
  logic [31:0]      fix_word;
  logic             fix_corr;
  logic             fix_uncorr;

  edac_cfg_reg #(.BSZ_W(BSZ_W)) u_cfg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_i  (cfg_we_i),
    .bsz_i (cfg_bank_sz_i),
    .en_i  (cfg_edac_en_i),
    .bsz_o (bsz),
    .en_o  (edac_en)
  );

  edac_bank_dec #(.BSZ_W(BSZ_W), .NBANK(NBANK)) u_dec (
    .addr_i(req_addr_i),
    .bsz_i (bsz),
    .cs_o  (cs_dec)
  );

  always_comb begin
    for (int k = 0; k < NBYTE; k++) rd_word[DW-1-8*k -: 8] = rbuf_q[k];
  end

  edac_secded_chk u_chk (
    .en_i    (edac_q),
    .data_i  (rd_word),
    .ck_i    (rck_q),
    .data_o  (fix_word),
    .corr_o  (fix_corr),
    .uncorr_o(fix_uncorr)
  );

  assign req_ready_o = (st_q == ST_IDLE);
  assign accept      = req_valid_i && req_ready_o;
  assign last_acc    = edac_q ? (idx_q == IW'(NBYTE)) : (idx_q == IW'(NBYTE - 1));
  assign ck_addr     = {addr_q[31:28], 2'b11, ~addr_q[27:2]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      idx_q   <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      ck_q    <= '0;
      we_q    <= 1'b0;
      edac_q  <= 1'b0;
      cs_q    <= '0;
      rck_q   <= '0;
      for (int k = 0; k < NBYTE; k++) rbuf_q[k] <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (accept) begin
          st_q    <= ST_ACC;
          idx_q   <= '0;
          addr_q  <= {req_addr_i[31:2], 2'b00};
          wdata_q <= req_wdata_i;
          ck_q    <= ck_encode(req_wdata_i);
          we_q    <= req_we_i;
          edac_q  <= edac_en;
          cs_q    <= cs_dec;  // decoded once, held for check byte too
        end
        ST_ACC: begin
          if (idx_q < IW'(NBYTE)) rbuf_q[idx_q[IW-2:0]] <= mem_rdata_i;
          else                    rck_q <= mem_rdata_i;
          if (last_acc) st_q <= ST_RESP;
          else          idx_q <= idx_q + 1'b1;
        end
        ST_RESP: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_cs_o    = '0;
    mem_addr_o  = '0;
    mem_we_o    = 1'b0;
    mem_wdata_o = '0;
    if (st_q == ST_ACC) begin
      mem_cs_o = cs_q;
      mem_we_o = we_q && (cs_q != '0);
      if (idx_q < IW'(NBYTE)) begin
        mem_addr_o  = addr_q + 32'(idx_q);
        mem_wdata_o = wdata_q[DW-1-8*int'(idx_q) -: 8];
      end else begin
        mem_addr_o  = ck_addr;
        mem_wdata_o = ck_q;
      end
    end
  end

  assign rsp_valid_o  = (st_q == ST_RESP);
  assign rsp_rdata_o  = (rsp_valid_o && !we_q) ? fix_word : '0;
  assign rsp_corr_o   = rsp_valid_o && !we_q && fix_corr;
  assign rsp_uncorr_o = rsp_valid_o && !we_q && fix_uncorr;

  p_cs_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_ACC && idx_q != '0) |-> $stable(mem_cs_o));
  p_ck_addr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_ACC && idx_q == IW'(NBYTE)) |->
      (mem_addr_o[27:26] == 2'b11) && (mem_addr_o[31:28] == $past(mem_addr_o[31:28])));
  p_ck_msb_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && idx_q == IW'(NBYTE)) |-> !mem_wdata_o[7]);
  p_rsp_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o && req_ready_o);
  p_busy_no_cs_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> mem_cs_o == '0);
  p_noedac_four_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_ACC && !edac_q) |-> idx_q < IW'(NBYTE));
endmodule

// File: tb/sim_edac_byte_seq.sv
module sim_edac_byte_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_bsz = '0;
  logic        cfg_en = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_we = 1'b0;
  logic [31:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid, rsp_corr, rsp_uncorr;
  logic [31:0] rsp_rdata;
  logic [3:0]  mem_cs;
  logic [31:0] mem_addr;
  logic        mem_we;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = '0;

  always #2.5 clk = ~clk;

  edac_byte_seq u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_bank_sz_i(cfg_bsz), .cfg_edac_en_i(cfg_en),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_we_i(req_we),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .rsp_corr_o(rsp_corr), .rsp_uncorr_o(rsp_uncorr),
    .mem_cs_o(mem_cs), .mem_addr_o(mem_addr), .mem_we_o(mem_we),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata)
  );

  logic [7:0]  mem [bit [31:0]];
  logic [31:0] log_addr [16];
  logic [3:0]  log_cs [16];
  logic [7:0]  log_wd [16];
  int          log_n = 0;
  int          n_rsp = 0;
  int          n_chk = 0;
  int          n_bad = 0;
  int          cyc = 0;

  always @(posedge clk) begin
    if (|mem_cs) begin
      if (mem_we) mem[mem_addr] = mem_wdata;
      if (log_n < 16) begin
        log_addr[log_n] = mem_addr;
        log_cs[log_n]   = mem_cs;
        log_wd[log_n]   = mem_wdata;
      end
      log_n++;
    end
    if (rsp_valid) n_rsp++;
  end

  always @(negedge clk)
    mem_rdata = mem.exists(mem_addr) ? mem[mem_addr] : 8'h00;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog act=%0d exp=done", cyc);
      $display("test done: total=%0d bad=%0d", n_chk + 1, n_bad);
      $finish;
    end
  end

  function automatic logic [31:0] ck_of(input logic [31:0] a);
    return {a[31:28], 2'b11, ~a[27:2]};
  endfunction

  logic [31:0] r_data;
  logic        r_corr, r_unc;

  task automatic xfer(input bit we, input logic [31:0] a, input logic [31:0] d);
    int k;
    k = 0;
    while (!req_ready && k < 20) begin @(negedge clk); k++; end
    log_n = 0;
    req_we = we; req_addr = a; req_wdata = d; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    cfg_we = 1'b0;
    k = 0;
    while (!rsp_valid && k < 20) begin @(negedge clk); k++; end
    chk(rsp_valid, "R10 rsp", {63'd0, rsp_valid}, 64'd1);
    r_data = rsp_rdata; r_corr = rsp_corr; r_unc = rsp_uncorr;
    @(negedge clk);
    chk(!rsp_valid, "R10 pulse", {63'd0, rsp_valid}, 64'd0);
  endtask

  task automatic set_cfg(input logic [3:0] b, input bit en);
    @(negedge clk);
    cfg_we = 1'b1; cfg_bsz = b; cfg_en = en;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic flip(input logic [31:0] a, input int bitpos);
    mem[a] = mem[a] ^ (8'h01 << bitpos);
  endtask

  // {bank size, address, data, expected select}
  localparam logic [71:0] VEC [8] = '{
    {4'd6,  32'h0000_0010, 32'hDEAD_BEEF, 4'b0001},
    {4'd6,  32'h0008_0004, 32'h1234_5678, 4'b0010},
    {4'd6,  32'h0018_0100, 32'hFFFF_0000, 4'b1000},
    {4'd6,  32'h0020_0000, 32'hA5A5_A5A5, 4'b0000},
    {4'd15, 32'h1000_0000, 32'h0000_0001, 4'b0010},
    {4'd15, 32'h0FFF_FFFC, 32'h8000_0000, 4'b0001},
    {4'd0,  32'h0000_6000, 32'h0F0F_F0F0, 4'b1000},
    {4'd2,  32'h0000_8003, 32'hC001_D00D, 4'b0010}
  };

  initial begin
    logic [31:0] a, w, ab;
    logic [3:0]  ecs;
    int          seen;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(req_ready && mem_cs == 0 && !rsp_valid, "R1 reset",
        {req_ready, mem_cs, rsp_valid}, {1'b1, 4'd0, 1'b0});
    rst_n = 1'b1;
    @(negedge clk);
    // R1: default two 256 MiB banks, protection on
    xfer(1'b1, 32'h1000_0040, 32'h5555_AAAA);
    chk(log_n == 5 && log_cs[0] == 4'b0010, "R1 default cfg",
        {32'(log_n), 28'd0, log_cs[0]}, {32'd5, 32'd2});

    foreach (VEC[i]) begin
      a = VEC[i][67:36]; w = VEC[i][35:4]; ecs = VEC[i][3:0];
      ab = {a[31:2], 2'b00};
      set_cfg(VEC[i][71:68], 1'b1);
      xfer(1'b1, a, w);
      if (ecs == 4'b0000) begin
        chk(log_n == 0, "R4 out of range", 64'(log_n), 64'd0);
      end else begin
        chk(log_n == 5, "R2 access count", 64'(log_n), 64'd5);
        for (int k = 0; k < 4; k++)
          chk(log_addr[k] == ab + 32'(k) && log_wd[k] == w[31-8*k -: 8], "R2 byte order",
              {log_addr[k], 24'd0, log_wd[k]}, {ab + 32'(k), 24'd0, w[31-8*k -: 8]});
        chk(log_addr[4] == ck_of(ab), "R3 check addr", 64'(log_addr[4]), 64'(ck_of(ab)));
        for (int k = 0; k < 5; k++)
          chk(log_cs[k] == ecs, "R4 R5 select", 64'(log_cs[k]), 64'(ecs));
        chk(!log_wd[4][7], "R6 check msb", 64'(log_wd[4]), 64'(log_wd[4] & 8'h7F));
        xfer(1'b0, a, 32'h0);
        chk(r_data == w && !r_corr && !r_unc, "R6 clean read",
            {r_data, 30'd0, r_corr, r_unc}, {w, 32'd0});
      end
    end

    // R7: every single data/code bit flip is corrected
    set_cfg(4'd6, 1'b1);
    a = 32'h0000_0040; w = 32'h3C96_E10B;
    xfer(1'b1, a, w);
    for (int b = 0; b < 39; b++) begin
      if (b < 32) flip(a + 32'(3 - b / 8), b % 8);
      else        flip(ck_of(a), b - 32);
      xfer(1'b0, a, 32'h0);
      chk(r_data == w && r_corr && !r_unc, $sformatf("R7 flip bit %0d", b),
          {r_data, 30'd0, r_corr, r_unc}, {w, 30'd0, 2'b10});
      if (b < 32) flip(a + 32'(3 - b / 8), b % 8);
      else        flip(ck_of(a), b - 32);
    end

    // R8: double errors
    flip(a + 3, 0); flip(a + 2, 1);
    xfer(1'b0, a, 32'h0);
    chk(r_data == (w ^ 32'h0000_0201) && r_unc && !r_corr, "R8 two data bits",
        {r_data, 30'd0, r_corr, r_unc}, {w ^ 32'h0000_0201, 30'd0, 2'b01});
    flip(a + 3, 0); flip(a + 2, 1);
    flip(a + 0, 5); flip(ck_of(a), 2);
    xfer(1'b0, a, 32'h0);
    chk(r_data == (w ^ 32'h2000_0000) && r_unc && !r_corr, "R8 data+code bit",
        {r_data, 30'd0, r_corr, r_unc}, {w ^ 32'h2000_0000, 30'd0, 2'b01});
    flip(a + 0, 5); flip(ck_of(a), 2);

    // R9: protection off
    set_cfg(4'd6, 1'b0);
    a = 32'h0000_0100; w = 32'h0BAD_F00D;
    xfer(1'b1, a, w);
    chk(log_n == 4, "R9 four accesses", 64'(log_n), 64'd4);
    flip(a + 1, 3);
    xfer(1'b0, a, 32'h0);
    chk(log_n == 4 && r_data == (w ^ 32'h0008_0000) && !r_corr && !r_unc, "R9 raw read",
        {r_data, 30'd0, r_corr, r_unc}, {w ^ 32'h0008_0000, 32'd0});

    // R10: request raised while busy is ignored
    set_cfg(4'd6, 1'b1);
    @(negedge clk);
    seen = n_rsp;
    log_n = 0;
    req_we = 1'b1; req_addr = 32'h0000_0200; req_wdata = 32'h1111_2222; req_valid = 1'b1;
    @(negedge clk);
    req_addr = 32'h0000_0300;
    repeat (3) @(negedge clk);
    req_valid = 1'b0;
    repeat (6) @(negedge clk);
    chk(n_rsp - seen == 1, "R10 one response", 64'(n_rsp - seen), 64'd1);
    chk(log_n == 5 && log_addr[0] == 32'h0000_0200, "R10 busy ignored",
        {32'(log_n), log_addr[0]}, {32'd5, 32'h0000_0200});

    // R11: config write on the accept edge applies to the next request
    cfg_we = 1'b1; cfg_bsz = 4'd15; cfg_en = 1'b1;
    xfer(1'b1, 32'h0008_0000, 32'h7777_8888);
    chk(log_cs[0] == 4'b0010, "R11 old size used", 64'(log_cs[0]), 64'd2);
    xfer(1'b1, 32'h0008_0000, 32'h7777_8888);
    chk(log_cs[0] == 4'b0001, "R11 new size used", 64'(log_cs[0]), 64'd1);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule